// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives a periodic oversample tick and a baud tick from the peripheral clock. Software programs it through a small byte-wide register write port with two registers. Together they form a 12-bit divider value and a 4-bit signed scale. A scale of zero or more selects integer division followed by a power-of-two prescaler. A negative scale selects accumulator-based fractional counting, which gives finer rate steps than integer division can.

The high register only stages its contents. A write to the low register loads the full divider and scale into the active setting and restarts every counter. A transfer in flight is not protected when this happens. The oversample tick feeds a receiver, and the baud tick is raised on every sixteenth oversample tick. The reserved scale code is decoded as zero and sets a sticky error flag. It still reads back exactly as written.

Top module: `baud_tick_gen`

## Requirements
- R1: After synchronous reset both registers read 0 and `scale_err` is 0. With the all-zero setting, `os_tick` is high in every cycle starting with the first cycle after reset.
- R2: Reading address 0 returns the low register and reading address 1 returns the high register. Both return exactly the byte last written, including the reserved scale code.
- R3: A write to address 1 leaves the tick pattern unchanged. The staged value takes effect only at the next write to address 0.
- R4: A write to address 0 loads divider D = {high[3:0], data} and scale code high[7:4], and restarts all counting. Cycle n = 0 is the cycle right after the write edge, and the tick pattern is counted from there.
- R5: With scale s in 0..7, `os_tick` is high in cycle n exactly when (n+1) is a multiple of P = (D+1)·2^s.
- R6: With scale s in -7..-1 and m = -s, let T = D + 2^m. Then `os_tick` is high in cycle n exactly when floor((n+1)·2^m / T) > floor(n·2^m / T). The mean period is D·2^s + 1 clocks.
- R7: Scale code 1000 is decoded as scale 0 when it is loaded.
- R8: A write of scale code 1000 to address 1 sets `scale_err` from the next cycle on, and it stays set until reset.
- R9: `baud_tick` is high together with the 16th, 32nd, 48th, ... `os_tick` counted from the last restart, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: divider low byte, 1: scale[7:4] and divider high bits[3:0] |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read select, same encoding as wr_addr |
| rd_data | output | 8 | Register read data (combinational) |
| os_tick | output | 1 | Single-cycle oversample tick |
| baud_tick | output | 1 | Single-cycle baud tick, one per 16 oversample ticks |
| scale_err | output | 1 | Sticky flag: reserved scale code was written |

## Verification
Both ticks are decoded combinationally from registered counter state. After a low-byte write at edge E, the pattern starts in the cycle just after E: cycle 0 is high only for a period of one, and otherwise the first tick lands in cycle P-1 of the integer mode. Register reads and `scale_err` reflect a write in the cycle after its edge. The bench drives each write just after a falling edge. At every falling edge it compares all four outputs with a behavioural model indexed by the cycle count since the last restart. It does this for integer periods, fractional periods, a restart part-way through a run, and reserved-code loads.

// File: rtl/baud_gen_pkg.sv
// Package: shared widths, scale type and scale decode helpers for the
// baud tick generator. Assumes a 4-bit two's complement scale field.
package baud_gen_pkg;
    localparam int SCALE_W   = 4;
    localparam int REG_W     = 8;
    localparam int MAX_SHIFT = (1 << (SCALE_W - 1)) - 1;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

    typedef logic signed [SCALE_W-1:0] scale_t;

    // True for the reserved most-negative code
    function automatic logic scale_reserved(input logic [SCALE_W-1:0] code);
        return code == {1'b1, {(SCALE_W-1){1'b0}}};
    endfunction

    // Scale actually used: reserved code maps to zero
    function automatic scale_t scale_effective(input logic [SCALE_W-1:0] code);
        return scale_reserved(code) ? scale_t'(0) : scale_t'(code);
    endfunction
endpackage

// File: rtl/baud_regs.sv
// Register file: holds the low and high bytes, stages the high byte and
// loads the active divider and scale on a low-byte write. Raises a sticky
// flag when the reserved scale code is written. Assumes DIV_W > REG_W.
module baud_regs
    import baud_gen_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic [DIV_W-1:0] act_div,
    output scale_t           act_scale,
    output logic             restart,
    output logic             scale_err
);
    localparam int HI_DIV_W = DIV_W - REG_W;

    logic [REG_W-1:0] lo_q, hi_q;
    logic             hi_wr;

    assign restart = wr_en && !wr_addr;
    assign hi_wr   = wr_en && wr_addr;
    assign rd_data = rd_addr ? hi_q : lo_q;

    // Stored register bytes, written as-is
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (restart) begin
            lo_q <= wr_data;
        end else if (hi_wr) begin
            hi_q <= wr_data;
        end
    end

    // Active setting, loaded only by a low-byte write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_div   <= '0;
            act_scale <= '0;
        end else if (restart) begin
            act_div   <= {hi_q[HI_DIV_W-1:0], wr_data};
            act_scale <= scale_effective(hi_q[REG_W-1 -: SCALE_W]);
        end
    end

    // Sticky reserved-code flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            scale_err <= 1'b0;
        else if (hi_wr && scale_reserved(wr_data[REG_W-1 -: SCALE_W]))
            scale_err <= 1'b1;
    end

    p_hi_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> ($stable(act_div) && $stable(act_scale)));
    p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && wr_data[REG_W-1 -: SCALE_W] == 4'b1000) |=> scale_err);
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scale_err |=> scale_err);
endmodule

// File: rtl/baud_int_div.sv
// Integer divider: an inner counter runs 0..div, and an outer prescaler
// counts 2^shift inner wraps. The tick is high on the last cycle of each
// period of (div+1)*2^shift clocks. Restart clears both counters.
module baud_int_div
    import baud_gen_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [DIV_W-1:0]   div,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PRE_W = MAX_SHIFT;

    logic [DIV_W-1:0] inner_q;
    logic [PRE_W-1:0] pre_q, pre_last;
    logic             inner_wrap;

    assign pre_last   = (PRE_W'(1) << shift) - PRE_W'(1);
    assign inner_wrap = (inner_q == div);
    assign tick       = inner_wrap && (pre_q == pre_last);

    // Inner count up to div, then step the prescaler
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            inner_q <= '0;
            pre_q   <= '0;
        end else if (inner_wrap) begin
            inner_q <= '0;
            pre_q   <= (pre_q == pre_last) ? '0 : pre_q + PRE_W'(1);
        end else begin
            inner_q <= inner_q + DIV_W'(1);
        end
    end

    p_inner_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inner_q <= div);
    p_pre_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= pre_last);
endmodule

// File: rtl/baud_frac_div.sv
// Fractional divider: each clock adds 2^fbits to an accumulator. When the
// sum reaches div + 2^fbits a tick is issued and that amount is removed,
// so the mean period is div/2^fbits + 1 clocks. Restart clears the sum.
module baud_frac_div
    import baud_gen_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [DIV_W-1:0]   div,
    input  logic [SHIFT_W-1:0] fbits,
    output logic               tick
);
    localparam int ACC_W = DIV_W + 2;

    logic [ACC_W-1:0] acc_q, step, sum, thr;

    assign step = ACC_W'(1) << fbits;
    assign sum  = acc_q + step;
    assign thr  = ACC_W'(div) + step;
    assign tick = (sum >= thr);

    // Accumulate and wrap at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            acc_q <= '0;
        else
            acc_q <= tick ? sum - thr : sum;
    end

    p_acc_below_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < thr);
endmodule

// File: rtl/baud_os_count.sv
// Oversample counter: counts oversample ticks since restart and flags the
// one that completes each group of RATIO as the baud tick. Assumes RATIO > 1.
module baud_os_count #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic os_tick,
    output logic baud_tick
);
    localparam int CNT_W = $clog2(RATIO);

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last      = (cnt_q == CNT_W'(RATIO - 1));
    assign baud_tick = os_tick && last;

    // Count oversample ticks modulo RATIO
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt_q <= '0;
        else if (os_tick)
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end

    p_baud_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);
endmodule

// File: rtl/baud_tick_gen.sv
// Top: register file, integer and fractional dividers, and the oversample
// counter. The sign of the active scale selects which divider drives the
// oversample tick. A low-byte write restarts all counters.
module baud_tick_gen
    import baud_gen_pkg::*;
#(
    parameter int DIV_W    = 12,
    parameter int OS_RATIO = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             os_tick,
    output logic             baud_tick,
    output logic             scale_err
);
    logic [DIV_W-1:0]   act_div;
    scale_t             act_scale;
    logic               restart, use_frac, int_tick, frac_tick;
    logic [SCALE_W-1:0] neg_scale;
    logic [SHIFT_W-1:0] shift, fbits;

    assign use_frac  = act_scale[SCALE_W-1];
    assign neg_scale = SCALE_W'(-act_scale);
    assign shift     = use_frac ? '0 : act_scale[SHIFT_W-1:0];
    assign fbits     = neg_scale[SHIFT_W-1:0];
    assign os_tick   = use_frac ? frac_tick : int_tick;

    baud_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .act_div(act_div), .act_scale(act_scale), .restart(restart),
        .scale_err(scale_err)
    );

    baud_int_div #(.DIV_W(DIV_W)) u_int (
        .clk(clk), .rst_n(rst_n), .restart(restart), .div(act_div),
        .shift(shift), .tick(int_tick)
    );

    baud_frac_div #(.DIV_W(DIV_W)) u_frac (
        .clk(clk), .rst_n(rst_n), .restart(restart), .div(act_div),
        .fbits(fbits), .tick(frac_tick)
    );

    baud_os_count #(.RATIO(OS_RATIO)) u_os (
        .clk(clk), .rst_n(rst_n), .restart(restart), .os_tick(os_tick),
        .baud_tick(baud_tick)
    );

    p_restart_no_baud_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !baud_tick);
    p_baud_needs_os_r9: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> os_tick);
endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       os_tick, baud_tick, scale_err;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // Behavioural model state
    int     m_lo = 0, m_hi = 0, m_div = 0, m_scale = 0;
    bit     m_err = 1'b0;
    longint m_k = 0;
    longint m_osn = 0;

    always #10 clk = ~clk;

    baud_tick_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .os_tick(os_tick), .baud_tick(baud_tick), .scale_err(scale_err)
    );

    function automatic bit exp_os();
        longint p, t, mm;
        if (m_scale >= 0) begin
            p = longint'(m_div + 1) << m_scale;
            return ((m_k + 1) % p) == 0;
        end
        mm = -m_scale;
        t  = m_div + (longint'(1) << mm);
        return (((m_k + 1) << mm) / t) != ((m_k << mm) / t);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, m_k, act, exp);
        end
    endtask

    task automatic compare();
        bit e;
        e = exp_os();
        chk(cur_req, os_tick, e);
        chk("R9", baud_tick, e && (m_osn % 16 == 15));
        chk("R2", rd_data, rd_addr ? m_hi : m_lo);
        chk("R8", scale_err, m_err);
    endtask

    task automatic model_edge(input bit we, input bit a, input int d);
        bit e;
        int c;
        e = exp_os();
        if (we && !a) begin
            m_lo    = d;
            m_div   = ((m_hi & 15) << 8) | d;
            c       = m_hi >> 4;
            m_scale = (c == 8) ? 0 : ((c >= 8) ? c - 16 : c);
            m_k     = 0;
            m_osn   = 0;
        end else begin
            if (e) m_osn++;
            m_k++;
        end
        if (we && a) begin
            m_hi = d;
            if ((d >> 4) == 8) m_err = 1'b1;
        end
    endtask

    // One clock: check outputs, apply inputs, advance model
    task automatic cyc(input bit we, input bit a, input int d, input bit ra);
        compare();
        wr_en = we; wr_addr = a; wr_data = 8'(d); rd_addr = ra;
        @(posedge clk);
        model_edge(we, a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, i[0]);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values of registers and flag
        chk("R1", rd_data, 0);
        chk("R1", scale_err, 0);
        rst_n = 1'b1;
        cur_req = "R1";
        idle(40);
        // R3: staging only, pattern stays one tick per clock
        cur_req = "R3";
        cyc(1'b1, 1'b1, 8'h20, 1'b1);
        idle(40);
        // R5: D=5, s=2 -> period 24
        cur_req = "R5";
        cyc(1'b1, 1'b0, 8'h05, 1'b0);
        idle(800);
        // R6: s=-3, D=100 -> T=108
        cur_req = "R6";
        cyc(1'b1, 1'b1, 8'hD0, 1'b1);
        cyc(1'b1, 1'b0, 100, 1'b0);
        idle(1500);
        // R4: restart part-way through a run
        cur_req = "R4";
        cyc(1'b1, 1'b0, 37, 1'b0);
        idle(1000);
        // R6: s=-7, D=4095
        cur_req = "R6";
        cyc(1'b1, 1'b1, 8'h9F, 1'b1);
        cyc(1'b1, 1'b0, 8'hFF, 1'b0);
        idle(1200);
        // R6: s=-1, D=0 -> one tick per clock
        cyc(1'b1, 1'b1, 8'hF0, 1'b1);
        cyc(1'b1, 1'b0, 0, 1'b0);
        idle(40);
        // R5: s=7, D=3 -> period 512
        cur_req = "R5";
        cyc(1'b1, 1'b1, 8'h70, 1'b1);
        cyc(1'b1, 1'b0, 3, 1'b0);
        idle(8400);
        // R5: s=3, D=0 -> period 8
        cyc(1'b1, 1'b1, 8'h30, 1'b1);
        cyc(1'b1, 1'b0, 0, 1'b0);
        idle(300);
        // R7 and R8: reserved code, D=0x302 at scale 0 -> period 771
        cur_req = "R7";
        cyc(1'b1, 1'b1, 8'h83, 1'b1);
        idle(10);
        cyc(1'b1, 1'b0, 8'h02, 1'b1);
        idle(1700);
        // R8: flag stays set after a valid code
        cyc(1'b1, 1'b1, 8'h10, 1'b1);
        idle(20);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule